// File: doc/BRIEF.md
# Match-Masked Indirect Configuration Window

This block sits on a simple register bus between a host and a device that exposes an address/data register pair. Most traffic passes straight through to the device. The address register is watched: when the host writes a value that a programmed match/mask entry accepts, the block opens a window. The block keeps the masked low bits of that value as a byte offset. From then on, host accesses to the data register are steered to a local configuration-space storage port at that offset. A downstream read is still issued for every data read, but its value is discarded while the window is open.

In the gated build, two further registers act as a switch for the whole window: a master register and an enable register. Both are written through to the device and also shadowed inside the block. Address decoding and data steering are active only while bit 0 of both shadows is set. While the switch is off, the window state is frozen and every access passes through.

One read may be outstanding at a time. The host waits for `h_rvalid` before it issues another access. Every read completes exactly one cycle after the device answers. This lets the local storage, which has a one-cycle synchronous read, be queried on the answer cycle.

Top module: `cfg_window_shim`

## Requirements
- R1: After reset the window is closed, the redirect offset is zero, both gate shadows are zero (gate closed) and `h_rvalid`, `d_req` and `c_req` are low.
- R2: Address-register writes (default offset 0x8) are always forwarded downstream with the unchanged value. Address-register reads pass through unchanged.
- R3: A write to the address register with the gate open hits an entry when (value AND NOT mask) equals match. On a hit the window opens, with offset = value AND mask. Default entries: match 0x1800 with mask 0xFF, and match 0x88000 with mask 0xFFF. The lowest-numbered hitting entry wins.
- R4: With the gate open, an address write that hits no entry closes the window.
- R5: A data-register read (default offset 0xC) is always issued downstream. While the window is open, the host receives instead the 32-bit local word read at the redirect offset.
- R6: A data-register write with the window open goes only to the local port (`c_we`=1, `c_addr` = offset) and is not forwarded. With the window closed it is forwarded downstream.
- R7: `h_rvalid` is asserted exactly one cycle after the cycle in which `d_rvalid` answers the outstanding read.
- R8: Writes to the master (0x0) and enable (0x4) registers are forwarded and shadowed. The gate is open only while bit 0 of both shadows is 1. While it is closed, address writes leave the window state unchanged and data accesses pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host access strobe (one cycle) |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | AW | Host register byte offset |
| h_wdata | input | DW | Host write data |
| h_rvalid | output | 1 | Host read result valid |
| h_rdata | output | DW | Host read result |
| d_req | output | 1 | Downstream access strobe |
| d_we | output | 1 | Downstream write (1) or read (0) |
| d_addr | output | AW | Downstream register byte offset |
| d_wdata | output | DW | Downstream write data |
| d_rvalid | input | 1 | Downstream read answer valid |
| d_rdata | input | DW | Downstream read answer |
| c_req | output | 1 | Local configuration access strobe |
| c_we | output | 1 | Local configuration write (1) or read (0) |
| c_addr | output | CAW | Local configuration byte offset |
| c_wdata | output | DW | Local configuration write data |
| c_rdata | input | DW | Local configuration read data, one cycle after a read strobe |

## Verification
A stuck or stale window flag shows up on the first data access after the address write that should have changed it. A read then returns device data where a local word was expected, or the reverse. A write reaches the wrong side, which shows at the next read-back or in the downstream write count. A wrong redirect offset returns a different local word on the first redirected read. A lost gate shadow either lets a closed-gate address write alter the window or keeps data steering off after the gate reopens. Each of these shows on the next data read. Response timing faults show on every read as a latency other than one cycle after `d_rvalid`.

// File: rtl/cfgwin_pkg.sv
`timescale 1ns/1ps
package cfgwin_pkg;

    // Entry test: every bit outside the mask must equal the match value.
    function automatic logic entry_hit(input logic [31:0] value,
                                       input logic [31:0] match,
                                       input logic [31:0] mask);
        return (value & ~mask) == match;
    endfunction

endpackage

// File: rtl/cfgwin_match.sv
`timescale 1ns/1ps
module cfgwin_match #(
    parameter int CAW       = 12,
    parameter int NUM_MATCH = 2,
    parameter logic [NUM_MATCH*32-1:0] MATCH_TBL = {32'h0008_8000, 32'h0000_1800},
    parameter logic [NUM_MATCH*32-1:0] MASK_TBL  = {32'h0000_0FFF, 32'h0000_00FF}
) (
    input  logic [31:0]    value,
    output logic           hit,
    output logic [CAW-1:0] hit_ofs
);
    import cfgwin_pkg::*;

    logic [NUM_MATCH-1:0]  hit_vec;
    logic [CAW-1:0]        ofs_vec [NUM_MATCH];

    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_entry
        localparam logic [31:0] MV = MATCH_TBL[i*32 +: 32];
        localparam logic [31:0] KV = MASK_TBL[i*32 +: 32];
        assign hit_vec[i] = entry_hit(value, MV, KV);
        assign ofs_vec[i] = value[CAW-1:0] & KV[CAW-1:0];
    end

    // Lowest index has priority: scan from the top so it is written last.
    always_comb begin
        hit     = 1'b0;
        hit_ofs = '0;
        for (int i = NUM_MATCH - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit     = 1'b1;
                hit_ofs = ofs_vec[i];
            end
        end
    end
endmodule

// File: rtl/cfgwin_gate.sv
`timescale 1ns/1ps
module cfgwin_gate #(
    parameter bit GATED = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_master,
    input  logic wr_enable,
    input  logic wbit,
    output logic gate_open
);
    typedef struct packed {
        logic master;
        logic enable;
    } gate_t;

    gate_t g_q, g_d;

    always_comb begin
        g_d = g_q;
        if (wr_master) g_d.master = wbit;
        if (wr_enable) g_d.enable = wbit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign gate_open = GATED ? (g_q.master & g_q.enable) : 1'b1;

    p_shadow_master_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_master |=> g_q.master == $past(wbit));
    p_shadow_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enable |=> g_q.enable == $past(wbit));
endmodule

// File: rtl/cfg_window_shim.sv
`timescale 1ns/1ps
module cfg_window_shim #(
    parameter int AW        = 4,
    parameter int DW        = 32,
    parameter int CAW       = 12,
    parameter int NUM_MATCH = 2,
    parameter logic [NUM_MATCH*32-1:0] MATCH_TBL = {32'h0008_8000, 32'h0000_1800},
    parameter logic [NUM_MATCH*32-1:0] MASK_TBL  = {32'h0000_0FFF, 32'h0000_00FF},
    parameter logic [AW-1:0] ADDR_OFS   = 4'h8,
    parameter logic [AW-1:0] DATA_OFS   = 4'hC,
    parameter bit            GATED      = 1'b1,
    parameter logic [AW-1:0] MASTER_OFS = 4'h0,
    parameter logic [AW-1:0] ENABLE_OFS = 4'h4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           h_req,
    input  logic           h_we,
    input  logic [AW-1:0]  h_addr,
    input  logic [DW-1:0]  h_wdata,
    output logic           h_rvalid,
    output logic [DW-1:0]  h_rdata,
    output logic           d_req,
    output logic           d_we,
    output logic [AW-1:0]  d_addr,
    output logic [DW-1:0]  d_wdata,
    input  logic           d_rvalid,
    input  logic [DW-1:0]  d_rdata,
    output logic           c_req,
    output logic           c_we,
    output logic [CAW-1:0] c_addr,
    output logic [DW-1:0]  c_wdata,
    input  logic [DW-1:0]  c_rdata
);
    typedef struct packed {
        logic           win_en;
        logic [CAW-1:0] win_ofs;
        logic           rd_pend;
        logic           rd_redir;
        logic           rsp;
        logic [DW-1:0]  rd_data;
    } st_t;

    st_t s_q, s_d;

    logic           gate_open;
    logic           hit;
    logic [CAW-1:0] hit_ofs;

    cfgwin_gate #(.GATED(GATED)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_master (h_req && h_we && h_addr == MASTER_OFS),
        .wr_enable (h_req && h_we && h_addr == ENABLE_OFS),
        .wbit      (h_wdata[0]),
        .gate_open (gate_open)
    );

    cfgwin_match #(
        .CAW(CAW), .NUM_MATCH(NUM_MATCH),
        .MATCH_TBL(MATCH_TBL), .MASK_TBL(MASK_TBL)
    ) u_match (
        .value   (h_wdata[31:0]),
        .hit     (hit),
        .hit_ofs (hit_ofs)
    );

    logic acc_addr_wr, acc_data, redir_wr, ans_now;
    assign acc_addr_wr = h_req && h_we && (h_addr == ADDR_OFS) && gate_open;
    assign acc_data    = h_req && (h_addr == DATA_OFS) && gate_open;
    assign redir_wr    = acc_data && h_we && s_q.win_en;
    assign ans_now     = d_rvalid && s_q.rd_pend;

    always_comb begin
        s_d     = s_q;
        s_d.rsp = 1'b0;
        if (acc_addr_wr) begin
            s_d.win_en = hit;
            if (hit) s_d.win_ofs = hit_ofs;
        end
        if (h_req && !h_we) begin
            s_d.rd_pend  = 1'b1;
            s_d.rd_redir = acc_data && s_q.win_en;
        end
        if (ans_now) begin
            s_d.rd_pend = 1'b0;
            s_d.rsp     = 1'b1;
            s_d.rd_data = d_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign d_req    = h_req && !redir_wr;
    assign d_we     = h_we;
    assign d_addr   = h_addr;
    assign d_wdata  = h_wdata;

    assign c_req    = redir_wr || (ans_now && s_q.rd_redir);
    assign c_we     = redir_wr;
    assign c_addr   = s_q.win_ofs;
    assign c_wdata  = h_wdata;

    assign h_rvalid = s_q.rsp;
    assign h_rdata  = s_q.rd_redir ? c_rdata : s_q.rd_data;

    p_hit_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr_wr && hit) |=> (s_q.win_en && s_q.win_ofs == $past(hit_ofs)));
    p_miss_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr_wr && !hit) |=> !s_q.win_en);
    p_open_write_local_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && h_we && h_addr == DATA_OFS && gate_open && s_q.win_en)
        |-> (c_req && c_we && !d_req));
    p_rsp_after_answer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ans_now |=> h_rvalid);
    p_rsp_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        h_rvalid |-> $past(d_rvalid));
    p_closed_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && h_we && h_addr == ADDR_OFS && !gate_open)
        |=> ($stable(s_q.win_en) && $stable(s_q.win_ofs)));
endmodule

// File: tb/tb_cfg_window_shim.sv
`timescale 1ns/1ps
module tb_cfg_window_shim;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req = 1'b0, h_we = 1'b0;
    logic [3:0]  h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic        h_rvalid;
    logic [31:0] h_rdata;
    logic        d_req, d_we;
    logic [3:0]  d_addr;
    logic [31:0] d_wdata;
    logic        d_rvalid;
    logic [31:0] d_rdata;
    logic        c_req, c_we;
    logic [11:0] c_addr;
    logic [31:0] c_wdata, c_rdata;

    always #2 clk = ~clk;   // 250 MHz

    cfg_window_shim dut (.*);

    // Device and local storage models
    logic [31:0] dev_reg [4];
    logic [31:0] cfg_mem [1024];
    int          rd_wait, ds_wr, ds_rd, cfg_wr;
    logic [1:0]  rd_idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) dev_reg[i] <= 32'hD000_0000 + i;
            for (int i = 0; i < 1024; i++) cfg_mem[i] <= 32'hC000_0000 | i;
            rd_wait <= 0; ds_wr <= 0; ds_rd <= 0; cfg_wr <= 0;
            d_rvalid <= 1'b0; d_rdata <= '0; c_rdata <= '0; rd_idx <= '0;
        end else begin
            d_rvalid <= 1'b0;
            if (rd_wait > 0) begin
                rd_wait <= rd_wait - 1;
                if (rd_wait == 1) begin
                    d_rvalid <= 1'b1;
                    d_rdata  <= dev_reg[rd_idx];
                end
            end
            if (d_req) begin
                if (d_we) begin
                    dev_reg[d_addr[3:2]] <= d_wdata;
                    ds_wr <= ds_wr + 1;
                end else begin
                    rd_idx  <= d_addr[3:2];
                    rd_wait <= 2;
                    ds_rd   <= ds_rd + 1;
                end
            end
            if (c_req) begin
                if (c_we) begin
                    cfg_mem[c_addr[11:2]] <= c_wdata;
                    cfg_wr <= cfg_wr + 1;
                end else begin
                    c_rdata <= cfg_mem[c_addr[11:2]];
                end
            end
        end
    end

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic host_write(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        h_req = 1'b1; h_we = 1'b1; h_addr = a; h_wdata = v;
        @(negedge clk);
        h_req = 1'b0; h_we = 1'b0;
    endtask

    task automatic host_read(input logic [3:0] a, output logic [31:0] v, output int lat);
        int dv;
        bit got;
        @(negedge clk);
        h_req = 1'b1; h_we = 1'b0; h_addr = a;
        @(negedge clk);
        h_req = 1'b0;
        dv = -100; got = 0; v = 'x; lat = -1;
        for (int n = 0; n < 40 && !got; n++) begin
            if (d_rvalid) dv = n;
            if (h_rvalid) begin
                v = h_rdata; lat = n - dv; got = 1;
            end else begin
                @(negedge clk);
            end
        end
        if (!got) begin
            n_chk++; n_bad++;
            $display("FAIL R7: no read response, actual none expected h_rvalid");
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R1 h_rvalid after reset", {31'b0, h_rvalid}, 32'd0);
        chk("R1 d_req after reset", {31'b0, d_req}, 32'd0);
        chk("R1 c_req after reset", {31'b0, c_req}, 32'd0);
    endtask

    task automatic t_gate_closed();
        logic [31:0] v; int lat, w0;
        // Gate shadows are zero after reset: matching address must not open.
        host_write(4'h8, 32'h0000_1804);
        chk("R2 address write forwarded", dev_reg[2], 32'h0000_1804);
        host_read(4'hC, v, lat);
        chk("R1/R8 gate closed data read passes", v, 32'hD000_0003);
        w0 = ds_wr;
        host_write(4'hC, 32'hAAAA_0001);
        chk("R8 gate closed data write forwarded", ds_wr, w0 + 1);
        chk("R8 gate closed data write value", dev_reg[3], 32'hAAAA_0001);
    endtask

    task automatic t_open_gate();
        logic [31:0] v; int lat;
        host_write(4'h0, 32'h0000_0001);
        host_write(4'h4, 32'h0000_0003);
        chk("R8 master forwarded", dev_reg[0], 32'h1);
        chk("R8 enable forwarded", dev_reg[1], 32'h3);
        // Address written while closed must not have opened the window.
        host_read(4'hC, v, lat);
        chk("R8 closed-gate address write ignored", v, 32'hAAAA_0001);
    endtask

    task automatic t_entry0();
        logic [31:0] v; int lat, r0;
        host_write(4'h8, 32'h0000_1804);
        host_read(4'h8, v, lat);
        chk("R2 address read passes", v, 32'h0000_1804);
        r0 = ds_rd;
        host_read(4'hC, v, lat);
        chk("R5 redirected read value", v, 32'hC000_0001);
        chk("R5 downstream read still issued", ds_rd, r0 + 1);
        chk("R7 response latency", lat, 32'd1);
    endtask

    task automatic t_redirect_write();
        logic [31:0] v; int lat, w0, c0;
        w0 = ds_wr; c0 = cfg_wr;
        host_write(4'hC, 32'h1234_5678);
        chk("R6 local write done", cfg_wr, c0 + 1);
        chk("R6 no downstream write", ds_wr, w0);
        chk("R6 local word stored", cfg_mem[1], 32'h1234_5678);
        chk("R6 device data untouched", dev_reg[3], 32'hAAAA_0001);
        host_read(4'hC, v, lat);
        chk("R6/R5 read back", v, 32'h1234_5678);
    endtask

    task automatic t_entry1();
        logic [31:0] v; int lat;
        host_write(4'h8, 32'h0008_8010);
        host_read(4'hC, v, lat);
        chk("R3 second entry offset 0x10", v, 32'hC000_0004);
        host_write(4'h8, 32'h0008_8FFC);
        host_read(4'hC, v, lat);
        chk("R3 second entry top offset", v, 32'hC000_03FF);
    endtask

    task automatic t_miss();
        logic [31:0] v; int lat;
        host_write(4'h8, 32'h0000_1804);
        host_write(4'h8, 32'h0000_1900);
        host_read(4'hC, v, lat);
        chk("R4 miss closes window", v, 32'hAAAA_0001);
        host_write(4'h8, 32'h0008_9000);
        host_read(4'hC, v, lat);
        chk("R4 masked-bit miss", v, 32'hAAAA_0001);
        chk("R7 pass-through latency", lat, 32'd1);
    endtask

    task automatic t_gate_hold();
        logic [31:0] v; int lat;
        host_write(4'h8, 32'h0000_1808);      // open, offset 8
        host_write(4'h0, 32'h0000_0000);      // gate closed
        host_read(4'hC, v, lat);
        chk("R8 closed gate passes data read", v, 32'hAAAA_0001);
        host_write(4'h8, 32'h0000_1900);      // would miss, must be ignored
        host_write(4'h0, 32'h0000_0003);      // reopen
        host_read(4'hC, v, lat);
        chk("R8 window state kept across closed gate", v, 32'hC000_0002);
    endtask

    task automatic t_reset_mid();
        logic [31:0] v; int lat;
        do_reset();
        t_reset_state();
        host_write(4'h0, 32'h1);
        host_write(4'h4, 32'h1);
        host_read(4'hC, v, lat);
        chk("R1 window closed after reset", v, 32'hD000_0003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_gate_closed();
        t_open_gate();
        t_entry0();
        t_redirect_write();
        t_entry1();
        t_miss();
        t_gate_hold();
        t_reset_mid();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule